// File: doc/BRIEF.md
# Instruction Cache Tag Invalidation Sequencer

This block owns the per-line valid flags of a 512-line instruction cache and the control register bits that govern them. Software, or a debugger, writes the control register to enable lookups, to inhibit single-line invalidation, or to start a bulk invalidation. A bulk invalidation steps through every line index, clearing one flag per clock. While it runs, any instruction fetch that arrives is stalled.

A single line can also be invalidated through either of two request ports, one for the processor core and one for the debug unit. Each port supplies the line-index bits of an address. The line-fill path sets a flag when a line has been loaded. The fetch path presents the index bits of its address and is told whether that line holds valid contents. Tag comparison, line data and the external bus are handled by other blocks.

A two-state machine drives the bulk invalidation. In SW_IDLE no invalidation runs. The transition SW_IDLE to SW_RUN is taken when a control write sets the invalidate-all bit. In SW_RUN a 9-bit counter supplies the index cleared in each cycle. The transition SW_RUN to SW_IDLE is taken in the cycle that clears index 511, and the invalidate-all bit returns to 0 at that same edge. Reset clears the control register and leaves the valid flags unchanged, so start-up code must run one bulk invalidation before it enables the cache.

Top module: `icache_inval_seq`

## Requirements
- R1: A control write with bit 24 = 1, made while `busy` is low, sets `busy` and reads back bit 24 = 1 from the next cycle on.
- R2: A bulk invalidation keeps `busy` high for exactly 512 cycles and clears every line flag. At the edge that ends it, bit 24 returns to 0, and the other control bits keep their values.
- R3: While `busy` is high, `fetch_stall` equals `fetch_req` and `fetch_line_valid` is 0.
- R4: A core single-line request clears only the flag at the index on `core_line_addr`, which carries address bits [12:4]. From the next cycle a lookup of that index misses, and other lines are unchanged.
- R5: The debug port works in the same way as the core port. It invalidates lines through `dbg_line_req`, and it writes the control register through `dbg_ctl_wr`, which can also start a bulk invalidation. Core and debug single-line requests in the same cycle both take effect. When both ports write the control register in the same cycle, the core data is stored.
- R6: When control bit 28 = 1, single-line requests from either port are ignored.
- R7: Reset makes `ctl_q` read 0, which also disables the cache, and leaves the valid flags unchanged.
- R8: `fetch_line_valid` is 1 only when `fetch_req` = 1, control bit 31 = 1, `busy` = 0 and the addressed flag is set. Otherwise it is 0.
- R9: Single-line requests and invalidate-all writes that arrive while `busy` is high are dropped. The running bulk invalidation still ends on schedule and does not restart.
- R10: `fill_we` sets the flag of `fill_idx`, and the change is visible from the next cycle. If an invalidation of the same index occurs in the same cycle, the invalidation wins and the flag ends cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_ctl_wr | input | 1 | Core write strobe for the control register |
| core_ctl_data | input | 32 | Core write data (bit 31 enable, bit 28 line-inhibit, bit 24 invalidate-all) |
| dbg_ctl_wr | input | 1 | Debug write strobe for the control register |
| dbg_ctl_data | input | 32 | Debug write data, same layout |
| ctl_q | output | 32 | Control register contents |
| busy | output | 1 | Bulk invalidation in progress |
| core_line_req | input | 1 | Core single-line invalidate request |
| core_line_addr | input | 9 | Address bits [12:4] of the core request |
| dbg_line_req | input | 1 | Debug single-line invalidate request |
| dbg_line_addr | input | 9 | Address bits [12:4] of the debug request |
| fill_we | input | 1 | Line-fill path marks a line valid |
| fill_idx | input | 9 | Line index being filled |
| fetch_req | input | 1 | Instruction fetch lookup |
| fetch_addr | input | 9 | Address bits [12:4] of the fetch |
| fetch_stall | output | 1 | Fetch must wait |
| fetch_line_valid | output | 1 | Addressed line is valid and usable |

## Verification
Lines at index 0, 511 and two middle values are filled and then invalidated from alternating ports. Probes of neighbouring lines confirm that each invalidation touches only its own index and that the port slice is decoded correctly. Bulk invalidation runs over lines that were filled beforehand, and its busy window is measured cycle by cycle. Within that window, a second invalidate-all write and a line request are injected, to show that they cannot lengthen or restart the sweep. Further directed cases set the inhibit bit, collide a fill with an invalidation at the same index, issue simultaneous requests on both ports, toggle the enable bit, and apply a reset over filled lines. These cases separate gating by the enable bit, the inhibit bit and the busy flag from the state of the flags themselves.

// File: rtl/icinv_pkg.sv
package icinv_pkg;

    // Control register bit positions are software-visible behaviour.
    localparam int unsigned CTL_EN_BIT       = 31;
    localparam int unsigned CTL_LINE_INH_BIT = 28;
    localparam int unsigned CTL_INV_ALL_BIT  = 24;

    typedef enum logic [0:0] {
        SW_IDLE = 1'b0,
        SW_RUN  = 1'b1
    } sweep_state_e;

endpackage

// File: rtl/icinv_sweep_fsm.sv
module icinv_sweep_fsm
    import icinv_pkg::*;
#(
    parameter int unsigned IDX_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic             done,
    output logic [IDX_W-1:0] sweep_idx
);

    localparam logic [IDX_W-1:0] LAST_IDX = '1;

    sweep_state_e     st, st_nxt;
    logic [IDX_W-1:0] cnt;

    always_comb begin
        st_nxt = st;
        unique case (st)
            SW_IDLE: st_nxt = start ? SW_RUN : SW_IDLE;
            SW_RUN:  st_nxt = (cnt == LAST_IDX) ? SW_IDLE : SW_RUN;
            default: st_nxt = SW_IDLE;
        endcase
    end

    // State register and sweep counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= SW_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_nxt;
            cnt <= (st == SW_RUN) ? cnt + 1'b1 : '0;
        end
    end

    // Outputs.
    always_comb begin
        busy = 1'b0;
        done = 1'b0;
        unique case (st)
            SW_IDLE: begin
                busy = 1'b0;
                done = 1'b0;
            end
            SW_RUN: begin
                busy = 1'b1;
                done = (cnt == LAST_IDX);
            end
            default: begin
                busy = 1'b0;
                done = 1'b0;
            end
        endcase
    end

    assign sweep_idx = cnt;

    p_sweep_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && sweep_idx == '0));

    p_sweep_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> (busy && sweep_idx == IDX_W'($past(sweep_idx) + 1'b1)));

    p_sweep_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

endmodule

// File: rtl/icinv_valid_array.sv
module icinv_valid_array #(
    parameter int unsigned IDX_W = 9,
    parameter int unsigned N_CLR = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_CLR-1:0]            clr_en,
    input  logic [N_CLR-1:0][IDX_W-1:0] clr_idx,
    input  logic                        set_en,
    input  logic [IDX_W-1:0]            set_idx,
    input  logic [IDX_W-1:0]            rd_idx,
    output logic                        rd_valid
);

    localparam int unsigned DEPTH = 1 << IDX_W;

    // Valid flags: deliberately not reset.
    logic [DEPTH-1:0] vbits;
    logic [DEPTH-1:0] kill;

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        logic [N_CLR-1:0] hit;
        for (genvar k = 0; k < N_CLR; k++) begin : g_port
            assign hit[k] = clr_en[k] && (clr_idx[k] == IDX_W'(i));
        end
        assign kill[i] = |hit;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (kill[i]) begin
                vbits[i] <= 1'b0;
            end else if (set_en && set_idx == IDX_W'(i)) begin
                vbits[i] <= 1'b1;
            end
        end
    end

    assign rd_valid = vbits[rd_idx];

    for (genvar k = 0; k < N_CLR; k++) begin : g_chk
        p_clear_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
            clr_en[k] |=> (vbits[$past(clr_idx[k])] == 1'b0));
    end

    p_fill_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !kill[set_idx]) |=> (vbits[$past(set_idx)] == 1'b1));

endmodule

// File: rtl/icache_inval_seq.sv
module icache_inval_seq
    import icinv_pkg::*;
#(
    parameter int unsigned IDX_W    = 9,
    parameter int unsigned LINE_LSB = 4,
    parameter int unsigned CTL_W    = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           core_ctl_wr,
    input  logic [CTL_W-1:0]               core_ctl_data,
    input  logic                           dbg_ctl_wr,
    input  logic [CTL_W-1:0]               dbg_ctl_data,
    output logic [CTL_W-1:0]               ctl_q,
    output logic                           busy,
    input  logic                           core_line_req,
    input  logic [LINE_LSB+IDX_W-1:LINE_LSB] core_line_addr,
    input  logic                           dbg_line_req,
    input  logic [LINE_LSB+IDX_W-1:LINE_LSB] dbg_line_addr,
    input  logic                           fill_we,
    input  logic [IDX_W-1:0]               fill_idx,
    input  logic                           fetch_req,
    input  logic [LINE_LSB+IDX_W-1:LINE_LSB] fetch_addr,
    output logic                           fetch_stall,
    output logic                           fetch_line_valid
);

    localparam int unsigned N_CLR = 3;

    logic [CTL_W-1:0] ctl_r;
    logic             ctl_wr;
    logic [CTL_W-1:0] ctl_wd;
    logic             sweep_start;
    logic             sweep_done;
    logic [IDX_W-1:0] sweep_idx;
    logic             inv_nxt;
    logic             line_ok;
    logic             line_valid;

    logic [N_CLR-1:0]            clr_en;
    logic [N_CLR-1:0][IDX_W-1:0] clr_idx;

    // Core write takes precedence over a same-cycle debug write.
    assign ctl_wr      = core_ctl_wr | dbg_ctl_wr;
    assign ctl_wd      = core_ctl_wr ? core_ctl_data : dbg_ctl_data;
    assign sweep_start = ctl_wr && ctl_wd[CTL_INV_ALL_BIT] && !busy;
    assign inv_nxt     = sweep_start ? 1'b1
                       : (sweep_done ? 1'b0 : ctl_r[CTL_INV_ALL_BIT]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_r <= '0;
        end else begin
            if (ctl_wr) begin
                ctl_r <= ctl_wd;
            end
            ctl_r[CTL_INV_ALL_BIT] <= inv_nxt;
        end
    end

    assign ctl_q = ctl_r;

    icinv_sweep_fsm #(
        .IDX_W (IDX_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (sweep_start),
        .busy      (busy),
        .done      (sweep_done),
        .sweep_idx (sweep_idx)
    );

    // Single-line requests: dropped when inhibited or while sweeping.
    assign line_ok = !ctl_r[CTL_LINE_INH_BIT] && !busy;

    assign clr_en[0]  = busy;
    assign clr_idx[0] = sweep_idx;
    assign clr_en[1]  = core_line_req && line_ok;
    assign clr_idx[1] = core_line_addr;
    assign clr_en[2]  = dbg_line_req && line_ok;
    assign clr_idx[2] = dbg_line_addr;

    icinv_valid_array #(
        .IDX_W (IDX_W),
        .N_CLR (N_CLR)
    ) u_valid (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_en   (clr_en),
        .clr_idx  (clr_idx),
        .set_en   (fill_we),
        .set_idx  (fill_idx),
        .rd_idx   (fetch_addr),
        .rd_valid (line_valid)
    );

    assign fetch_stall      = fetch_req && busy;
    assign fetch_line_valid = fetch_req && ctl_r[CTL_EN_BIT] && !busy && line_valid;

    p_inv_bit_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q[CTL_INV_ALL_BIT] == busy);

    p_reset_ctl_r7: assert property (@(posedge clk)
        !rst_n |=> (ctl_q == '0));

    p_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && busy) |-> (fetch_stall && !fetch_line_valid));

endmodule

// File: tb/icache_inval_seq_bench.sv
`timescale 1ns/1ps
module icache_inval_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        core_ctl_wr = 1'b0;
    logic [31:0] core_ctl_data = '0;
    logic        dbg_ctl_wr = 1'b0;
    logic [31:0] dbg_ctl_data = '0;
    logic [31:0] ctl_q;
    logic        busy;
    logic        core_line_req = 1'b0;
    logic [12:4] core_line_addr = '0;
    logic        dbg_line_req = 1'b0;
    logic [12:4] dbg_line_addr = '0;
    logic        fill_we = 1'b0;
    logic [8:0]  fill_idx = '0;
    logic        fetch_req = 1'b0;
    logic [12:4] fetch_addr = '0;
    logic        fetch_stall;
    logic        fetch_line_valid;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    icache_inval_seq u_icache_inval_seq (
        .clk              (clk),
        .rst_n            (rst_n),
        .core_ctl_wr      (core_ctl_wr),
        .core_ctl_data    (core_ctl_data),
        .dbg_ctl_wr       (dbg_ctl_wr),
        .dbg_ctl_data     (dbg_ctl_data),
        .ctl_q            (ctl_q),
        .busy             (busy),
        .core_line_req    (core_line_req),
        .core_line_addr   (core_line_addr),
        .dbg_line_req     (dbg_line_req),
        .dbg_line_addr    (dbg_line_addr),
        .fill_we          (fill_we),
        .fill_idx         (fill_idx),
        .fetch_req        (fetch_req),
        .fetch_addr       (fetch_addr),
        .fetch_stall      (fetch_stall),
        .fetch_line_valid (fetch_line_valid)
    );

    // op: 0 fill, 1 core line invalidate, 2 debug line invalidate
    typedef struct packed {
        logic [1:0] op;
        logic [8:0] idx;
        logic [8:0] probe;
        logic       exp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 9'd5,   9'd5,   1'b1},
        '{2'd0, 9'd300, 9'd300, 1'b1},
        '{2'd0, 9'd511, 9'd511, 1'b1},
        '{2'd0, 9'd0,   9'd0,   1'b1},
        '{2'd1, 9'd5,   9'd5,   1'b0},
        '{2'd1, 9'd300, 9'd511, 1'b1},
        '{2'd2, 9'd511, 9'd511, 1'b0},
        '{2'd2, 9'd7,   9'd0,   1'b1},
        '{2'd0, 9'd6,   9'd5,   1'b0},
        '{2'd1, 9'd0,   9'd0,   1'b0},
        '{2'd0, 9'd300, 9'd300, 1'b1},
        '{2'd2, 9'd300, 9'd300, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic ctl_write(input bit from_dbg, input logic [31:0] d);
        if (from_dbg) begin dbg_ctl_wr = 1'b1; dbg_ctl_data = d; end
        else begin core_ctl_wr = 1'b1; core_ctl_data = d; end
        step();
        core_ctl_wr = 1'b0;
        dbg_ctl_wr  = 1'b0;
    endtask

    task automatic do_fill(input logic [8:0] i);
        fill_we = 1'b1; fill_idx = i;
        step();
        fill_we = 1'b0;
    endtask

    task automatic line_inv(input bit from_dbg, input logic [8:0] i);
        if (from_dbg) begin dbg_line_req = 1'b1; dbg_line_addr = i; end
        else begin core_line_req = 1'b1; core_line_addr = i; end
        step();
        core_line_req = 1'b0;
        dbg_line_req  = 1'b0;
    endtask

    task automatic probe(input logic [8:0] i, output logic v);
        fetch_req = 1'b1; fetch_addr = i;
        #1;
        v = fetch_line_valid;
        fetch_req = 1'b0;
    endtask

    task automatic wait_idle();
        for (int g = 0; g < 600 && busy; g++) step();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic v;
        int n;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R7: reset state
        chk("R7 ctl after reset", ctl_q, 32'h0);
        chk("R7 busy after reset", {31'b0, busy}, 32'h0);

        // Fill some lines before the sweep so clearing is visible (R2)
        do_fill(9'd0);
        do_fill(9'd200);
        do_fill(9'd511);

        // R1: start bulk invalidation with cache enable
        ctl_write(1'b0, 32'h8100_0000);
        chk("R1 busy after start", {31'b0, busy}, 32'h1);
        chk("R1 invalidate bit reads 1", ctl_q, 32'h8100_0000);

        // R3: fetch stalled during sweep
        fetch_req = 1'b1; fetch_addr = 9'd0;
        #1;
        chk("R3 stall during sweep", {31'b0, fetch_stall}, 32'h1);
        chk("R3 no valid during sweep", {31'b0, fetch_line_valid}, 32'h0);
        fetch_req = 1'b0;

        // R2/R9: measure busy window with injected requests
        n = 0;
        while (busy && n < 600) begin
            n++;
            if (n == 101) begin
                core_ctl_wr = 1'b0; core_line_req = 1'b0;
            end
            if (n == 100) begin
                core_ctl_wr = 1'b1; core_ctl_data = 32'h8100_0000;
                core_line_req = 1'b1; core_line_addr = 9'd5;
            end
            step();
        end
        chk("R2 R9 sweep length", n, 512);
        chk("R2 invalidate bit self-clears", ctl_q, 32'h8000_0000);
        step();
        chk("R9 no restart after sweep", {31'b0, busy}, 32'h0);
        probe(9'd0, v);   chk("R2 line 0 cleared", {31'b0, v}, 32'h0);
        probe(9'd200, v); chk("R2 line 200 cleared", {31'b0, v}, 32'h0);
        probe(9'd511, v); chk("R2 line 511 cleared", {31'b0, v}, 32'h0);

        // Vector table: R4 R5 R10
        for (int k = 0; k < NV; k++) begin
            unique case (VECS[k].op)
                2'd0:    do_fill(VECS[k].idx);
                2'd1:    line_inv(1'b0, VECS[k].idx);
                default: line_inv(1'b1, VECS[k].idx);
            endcase
            probe(VECS[k].probe, v);
            chk($sformatf("R4 R5 R10 vector %0d", k), {31'b0, v}, {31'b0, VECS[k].exp});
        end

        // R6: inhibit bit blocks single-line invalidation
        ctl_write(1'b0, 32'h9000_0000);
        do_fill(9'd42);
        line_inv(1'b0, 9'd42);
        probe(9'd42, v); chk("R6 core request ignored", {31'b0, v}, 32'h1);
        line_inv(1'b1, 9'd42);
        probe(9'd42, v); chk("R6 debug request ignored", {31'b0, v}, 32'h1);
        ctl_write(1'b0, 32'h8000_0000);

        // R10: fill and invalidate on the same index in one cycle
        fill_we = 1'b1; fill_idx = 9'd77;
        core_line_req = 1'b1; core_line_addr = 9'd77;
        step();
        fill_we = 1'b0; core_line_req = 1'b0;
        probe(9'd77, v); chk("R10 invalidate beats fill", {31'b0, v}, 32'h0);

        // R5: both ports in the same cycle
        do_fill(9'd10);
        do_fill(9'd11);
        core_line_req = 1'b1; core_line_addr = 9'd10;
        dbg_line_req  = 1'b1; dbg_line_addr  = 9'd11;
        step();
        core_line_req = 1'b0; dbg_line_req = 1'b0;
        probe(9'd10, v); chk("R5 core line in dual cycle", {31'b0, v}, 32'h0);
        probe(9'd11, v); chk("R5 debug line in dual cycle", {31'b0, v}, 32'h0);

        // R8: enable gates the lookup
        do_fill(9'd300);
        ctl_write(1'b0, 32'h0000_0000);
        probe(9'd300, v); chk("R8 miss when disabled", {31'b0, v}, 32'h0);
        ctl_write(1'b0, 32'h8000_0000);
        probe(9'd300, v); chk("R8 hit when enabled", {31'b0, v}, 32'h1);
        #1;
        chk("R8 no valid without request", {31'b0, fetch_line_valid}, 32'h0);

        // R5: debug port starts a sweep; simultaneous writes favour core
        ctl_write(1'b1, 32'h8100_0000);
        chk("R5 debug starts sweep", {31'b0, busy}, 32'h1);
        wait_idle();
        probe(9'd300, v); chk("R5 debug sweep cleared line", {31'b0, v}, 32'h0);
        core_ctl_wr = 1'b1; core_ctl_data = 32'h8000_0000;
        dbg_ctl_wr  = 1'b1; dbg_ctl_data  = 32'h1000_0000;
        step();
        core_ctl_wr = 1'b0; dbg_ctl_wr = 1'b0;
        chk("R5 core write wins", ctl_q, 32'h8000_0000);

        // R7: reset keeps valid flags
        do_fill(9'd123);
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
        step();
        chk("R7 ctl cleared by reset", ctl_q, 32'h0);
        probe(9'd123, v); chk("R7 disabled after reset", {31'b0, v}, 32'h0);
        ctl_write(1'b0, 32'h8000_0000);
        probe(9'd123, v); chk("R7 flag kept over reset", {31'b0, v}, 32'h1);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule